// File: doc/BRIEF.md
# MSI Capture Vector Sets

This block turns inbound message-signalled interrupt writes into pending bits. It holds eight independent sets of 32 vectors each. Every set owns a programmable 64-bit capture address, a status word and an enable mask. When a posted memory write arrives on the inbound port, its address is compared against the capture address of every globally enabled set. On a match, the write data picks the status bit to raise inside that set. Software clears status bits by writing ones to them.

A 32-bit register bus gives software read and write access to all set registers and to a global set-enable word. Reads are combinational from the address. Writes take effect on the clock edge that samples them.

The block drives one pending flag per set toward a top-level aggregator. It also drives a one-cycle strobe that reports each inbound write it dropped.

Top module: `msi_capture_sets`

## Requirements
- R1: After synchronous reset, every capture address, status, enable and global set-enable register reads 0, all pending flags are 0 and the unmatched strobe is 0.
- R2: Set n's capture address low word is at 0xC00 + 0x10*n, its status at 0xC04 + 0x10*n and its enable mask at 0xC08 + 0x10*n. The capture address high word is at 0xC80 + 0x4*n. The global set-enable word is at 0x190, bit n gating set n. The address, enable and global registers read back what was last written to them. Any other address, including 0xC0C + 0x10*n, reads 0.
- R3: An inbound write whose 64-bit address equals set n's {high, low} capture address, while global bit n is 1 and the data is in the range 0 to 31, sets status bit (data) of set n. The new value is visible from the clock edge that samples the write.
- R4: A register write to a status word clears every bit written as 1. Bits written as 0 keep their value.
- R5: If a capture and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The pending flag of set n is 1 exactly when global bit n is 1 and at least one bit is set in both status and enable of set n. Clearing enable bits or global bits never changes the status word.
- R7: An inbound write is dropped when no globally enabled set's capture address matches it or when its data exceeds 31. A dropped write changes no status bit and drives the unmatched strobe high for exactly the one cycle after the sampling edge.
- R8: When several globally enabled sets hold the same capture address, only the lowest-numbered of them captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| iw_valid | input | 1 | Inbound posted write present this cycle |
| iw_addr | input | 64 | Inbound write address |
| iw_data | input | 32 | Inbound write data, carrying the vector number |
| set_pending_o | output | 8 | Per-set pending flag |
| unmatched_o | output | 1 | One-cycle strobe for each dropped inbound write |

## Verification
The assertions check these rules on every cycle:
- A status bit only rises after a capture and only falls after a status write.
- A captured bit is always set on the following cycle, even when it was cleared in that same cycle.
- The unmatched strobe is only raised by an inbound write.

Only the bench's scenarios can show the following:
- The register map and readback.
- That the right set and bit are chosen for a given address and data.
- The lowest-index choice when two sets share an address.
- The gating of the pending flags by the enable mask and the global enables.
- The dropping of writes to disabled sets, to unknown addresses and with out-of-range data.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int unsigned NUM_SETS    = 8;
    localparam int unsigned VEC_PER_SET = 32;
    localparam int unsigned REG_AW      = 12;
    localparam int unsigned REG_DW      = 32;
    localparam int unsigned CAP_AW      = 64;

    // fixed register layout
    localparam logic [REG_AW-1:0] GRP_BASE = 12'hC00;
    localparam logic [REG_AW-1:0] HI_BASE  = 12'hC80;
    localparam logic [REG_AW-1:0] GEN_ADDR = 12'h190;

    // register field selected by a bus address
    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_ADDR_LO,
        FLD_STATUS,
        FLD_ENABLE,
        FLD_ADDR_HI,
        FLD_GLOBAL
    } reg_field_e;

    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_cap_pkg::*;
#(
    parameter int unsigned NSETS = NUM_SETS,
    parameter int unsigned AW    = REG_AW,
    localparam int unsigned SIW  = idx_width(NSETS)
) (
    input  logic [AW-1:0]  addr,
    output reg_field_e     fld,
    output logic [SIW-1:0] idx
);

    always_comb begin
        fld = FLD_NONE;
        idx = '0;
        if (addr == GEN_ADDR) begin
            fld = FLD_GLOBAL;
        end
        for (int i = 0; i < NSETS; i++) begin
            // 16-byte register group per set
            if (addr[AW-1:4] == (AW-4)'((GRP_BASE >> 4) + i) && addr[1:0] == 2'b00) begin
                idx = SIW'(i);
                case (addr[3:2])
                    2'd0:    fld = FLD_ADDR_LO;
                    2'd1:    fld = FLD_STATUS;
                    2'd2:    fld = FLD_ENABLE;
                    default: fld = FLD_NONE;
                endcase
            end
            // one high address word per set
            if (addr[AW-1:2] == (AW-2)'((HI_BASE >> 2) + i) && addr[1:0] == 2'b00) begin
                idx = SIW'(i);
                fld = FLD_ADDR_HI;
            end
        end
    end

endmodule

// File: rtl/msi_vec_set.sv
module msi_vec_set
    import msi_cap_pkg::*;
#(
    parameter int unsigned NVEC = VEC_PER_SET,
    parameter int unsigned DW   = REG_DW,
    parameter int unsigned CAW  = CAP_AW,
    localparam int unsigned VIW = idx_width(NVEC)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           lo_we,
    input  logic           hi_we,
    input  logic           st_we,
    input  logic           en_we,
    input  logic [DW-1:0]  wdata,
    input  logic           cap_valid,
    input  logic [VIW-1:0] cap_bit,
    output logic [CAW-1:0] cap_addr,
    output logic [NVEC-1:0] status,
    output logic [NVEC-1:0] enable,
    output logic           pend_raw
);

    logic [NVEC-1:0] clr_mask;
    logic [NVEC-1:0] set_mask;
    logic [NVEC-1:0] status_nxt;

    always_comb begin
        clr_mask = st_we ? wdata[NVEC-1:0] : '0;
        set_mask = '0;
        if (cap_valid) begin
            set_mask[cap_bit] = 1'b1;
        end
        // set dominates a same-cycle clear
        status_nxt = (status & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr <= '0;
            status   <= '0;
            enable   <= '0;
        end else begin
            if (lo_we) cap_addr[DW-1:0]   <= wdata;
            if (hi_we) cap_addr[CAW-1:DW] <= wdata[CAW-DW-1:0];
            if (en_we) enable <= wdata[NVEC-1:0];
            status <= status_nxt;
        end
    end

    assign pend_raw = |(status & enable);

    AST_RISE_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status)) != '0) |-> $past(cap_valid)); // R3

    AST_FALL_NEEDS_W1C: assert property (@(posedge clk) disable iff (rst)
        ((~status & $past(status)) != '0) |-> $past(st_we)); // R4

    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(cap_valid) |-> status[$past(cap_bit)]); // R5

endmodule

// File: rtl/msi_capture_match.sv
module msi_capture_match
    import msi_cap_pkg::*;
#(
    parameter int unsigned NSETS = NUM_SETS,
    parameter int unsigned NVEC  = VEC_PER_SET,
    parameter int unsigned DW    = REG_DW,
    parameter int unsigned CAW   = CAP_AW,
    localparam int unsigned VIW  = idx_width(NVEC)
) (
    input  logic                      iw_valid,
    input  logic [CAW-1:0]            iw_addr,
    input  logic [DW-1:0]             iw_data,
    input  logic [NSETS-1:0][CAW-1:0] cap_addr,
    input  logic [NSETS-1:0]          set_en,
    output logic [NSETS-1:0]          hit,
    output logic [VIW-1:0]            bit_idx,
    output logic                      miss
);

    logic found;
    logic data_ok;

    always_comb begin
        hit     = '0;
        found   = 1'b0;
        bit_idx = iw_data[VIW-1:0];
        data_ok = (iw_data < DW'(NVEC));
        // lowest index takes priority
        for (int i = 0; i < NSETS; i++) begin
            if (!found && set_en[i] && cap_addr[i] == iw_addr) begin
                hit[i] = 1'b1;
                found  = 1'b1;
            end
        end
        if (!iw_valid || !data_ok) begin
            hit = '0;
        end
        miss = iw_valid && !(found && data_ok);
    end

endmodule

// File: rtl/msi_capture_sets.sv
module msi_capture_sets
    import msi_cap_pkg::*;
#(
    parameter int unsigned NSETS = NUM_SETS,
    parameter int unsigned NVEC  = VEC_PER_SET,
    parameter int unsigned AW    = REG_AW,
    parameter int unsigned DW    = REG_DW,
    parameter int unsigned CAW   = CAP_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             iw_valid,
    input  logic [CAW-1:0]   iw_addr,
    input  logic [DW-1:0]    iw_data,
    output logic [NSETS-1:0] set_pending_o,
    output logic             unmatched_o
);

    localparam int unsigned SIW = idx_width(NSETS);
    localparam int unsigned VIW = idx_width(NVEC);

    reg_field_e                sel_fld;
    logic [SIW-1:0]            sel_idx;
    logic [NSETS-1:0]          gen_en;
    logic [NSETS-1:0][CAW-1:0] cap_addr;
    logic [NSETS-1:0][NVEC-1:0] status_all;
    logic [NSETS-1:0][NVEC-1:0] enable_all;
    logic [NSETS-1:0]          pend_raw;
    logic [NSETS-1:0]          hit;
    logic [VIW-1:0]            bit_idx;
    logic                      miss;

    msi_reg_decode #(.NSETS(NSETS), .AW(AW)) u_dec (
        .addr (reg_addr),
        .fld  (sel_fld),
        .idx  (sel_idx)
    );

    msi_capture_match #(.NSETS(NSETS), .NVEC(NVEC), .DW(DW), .CAW(CAW)) u_match (
        .iw_valid (iw_valid),
        .iw_addr  (iw_addr),
        .iw_data  (iw_data),
        .cap_addr (cap_addr),
        .set_en   (gen_en),
        .hit      (hit),
        .bit_idx  (bit_idx),
        .miss     (miss)
    );

    for (genvar g = 0; g < NSETS; g++) begin : g_set
        logic here;
        assign here = reg_we && (sel_idx == SIW'(g));

        msi_vec_set #(.NVEC(NVEC), .DW(DW), .CAW(CAW)) u_set (
            .clk       (clk),
            .rst       (rst),
            .lo_we     (here && sel_fld == FLD_ADDR_LO),
            .hi_we     (here && sel_fld == FLD_ADDR_HI),
            .st_we     (here && sel_fld == FLD_STATUS),
            .en_we     (here && sel_fld == FLD_ENABLE),
            .wdata     (reg_wdata),
            .cap_valid (hit[g]),
            .cap_bit   (bit_idx),
            .cap_addr  (cap_addr[g]),
            .status    (status_all[g]),
            .enable    (enable_all[g]),
            .pend_raw  (pend_raw[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en      <= '0;
            unmatched_o <= 1'b0;
        end else begin
            if (reg_we && sel_fld == FLD_GLOBAL) gen_en <= reg_wdata[NSETS-1:0];
            unmatched_o <= miss;
        end
    end

    assign set_pending_o = pend_raw & gen_en;

    always_comb begin
        reg_rdata = '0;
        case (sel_fld)
            FLD_ADDR_LO: reg_rdata = cap_addr[sel_idx][DW-1:0];
            FLD_ADDR_HI: reg_rdata = cap_addr[sel_idx][CAW-1:DW];
            FLD_STATUS:  reg_rdata[NVEC-1:0] = status_all[sel_idx];
            FLD_ENABLE:  reg_rdata[NVEC-1:0] = enable_all[sel_idx];
            FLD_GLOBAL:  reg_rdata[NSETS-1:0] = gen_en;
            default:     reg_rdata = '0;
        endcase
    end

    AST_UNMATCHED_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        unmatched_o |-> $past(iw_valid)); // R7

endmodule

// File: tb/msi_capture_sets_tb.sv
module msi_capture_sets_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        iw_valid = 1'b0;
    logic [63:0] iw_addr = '0;
    logic [31:0] iw_data = '0;
    logic [7:0]  set_pending_o;
    logic        unmatched_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] m_st [8];
    logic [31:0] m_en [8];
    logic [7:0]  m_gen;

    // capture walk: {set[2:0], vector[4:0]}
    localparam logic [7:0] CAP_TAB [8] = '{8'h00, 8'h1F, 8'h65, 8'hFF,
                                           8'hB1, 8'h65, 8'h29, 8'hC0};

    always #2 clk = ~clk;

    msi_capture_sets u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iw_valid(iw_valid),
        .iw_addr(iw_addr), .iw_data(iw_data), .set_pending_o(set_pending_o),
        .unmatched_o(unmatched_o)
    );

    function automatic logic [11:0] grp(int n, int sub);
        return 12'(12'hC00 + 16 * n + 4 * sub);
    endfunction
    function automatic logic [11:0] hi_reg(int n);
        return 12'(12'hC80 + 4 * n);
    endfunction
    function automatic logic [63:0] set_addr(int n);
        return {32'(32'h0000_00A0 + n), 32'(32'hFE00_0000 + 256 * n)};
    endfunction
    function automatic logic [7:0] model_pend();
        logic [7:0] p;
        for (int n = 0; n < 8; n++) p[n] = m_gen[n] && ((m_st[n] & m_en[n]) != 0);
        return p;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic inb(logic [63:0] a, logic [31:0] d);
        @(negedge clk);
        iw_valid = 1'b1; iw_addr = a; iw_data = d;
        @(negedge clk);
        iw_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pending", 64'(set_pending_o), 0);
        chk("R1 unmatched", 64'(unmatched_o), 0);
        rd(grp(0, 0), v); chk("R1 lo0", 64'(v), 0);
        rd(grp(7, 1), v); chk("R1 st7", 64'(v), 0);
        rd(grp(7, 2), v); chk("R1 en7", 64'(v), 0);
        rd(hi_reg(7), v); chk("R1 hi7", 64'(v), 0);
        rd(12'h190, v);   chk("R1 gen", 64'(v), 0);

        // program all sets
        for (int n = 0; n < 8; n++) begin
            wr(grp(n, 0), set_addr(n)[31:0]);
            wr(hi_reg(n), set_addr(n)[63:32]);
            wr(grp(n, 2), 32'hFFFF_FFFF);
            m_st[n] = 0; m_en[n] = 32'hFFFF_FFFF;
        end
        wr(12'h190, 32'h0000_00FF);
        m_gen = 8'hFF;

        // R2 readback and holes
        rd(grp(3, 0), v);  chk("R2 lo3", 64'(v), 64'(set_addr(3)[31:0]));
        rd(hi_reg(3), v);  chk("R2 hi3", 64'(v), 64'(set_addr(3)[63:32]));
        rd(grp(3, 2), v);  chk("R2 en3", 64'(v), 64'hFFFF_FFFF);
        rd(12'h190, v);    chk("R2 gen", 64'(v), 64'hFF);
        rd(grp(0, 3), v);  chk("R2 hole C0C", 64'(v), 0);
        rd(12'h194, v);    chk("R2 hole 194", 64'(v), 0);
        chk("R2 no pending", 64'(set_pending_o), 0);

        // R3 capture walk
        for (int k = 0; k < 8; k++) begin
            int s, b;
            s = int'(CAP_TAB[k][7:5]);
            b = int'(CAP_TAB[k][4:0]);
            inb(set_addr(s), 32'(b));
            m_st[s] = m_st[s] | (32'h1 << b);
            chk("R7 no strobe on hit", 64'(unmatched_o), 0);
            rd(grp(s, 1), v);
            chk("R3 status", 64'(v), 64'(m_st[s]));
            chk("R6 pending", 64'(set_pending_o), 64'(model_pend()));
        end

        // R4 write-one-to-clear
        wr(grp(0, 1), 32'h0000_0001);
        m_st[0] = m_st[0] & ~32'h1;
        rd(grp(0, 1), v); chk("R4 clear one", 64'(v), 64'h8000_0000);
        wr(grp(3, 1), 32'h0);
        rd(grp(3, 1), v); chk("R4 zero keeps", 64'(v), 64'(m_st[3]));

        // R6 masking keeps status
        wr(grp(7, 2), 32'h0); m_en[7] = 0;
        chk("R6 mask pend7", 64'(set_pending_o), 64'(model_pend()));
        rd(grp(7, 1), v); chk("R6 masked status kept", 64'(v), 64'h8000_0000);
        wr(12'h190, 32'h0000_00DF); m_gen = 8'hDF;
        chk("R6 global gate pend5", 64'(set_pending_o), 64'(model_pend()));
        rd(grp(5, 1), v); chk("R6 gated status kept", 64'(v), 64'(m_st[5]));

        // R7 dropped writes
        inb(set_addr(5), 32'd3);
        chk("R7 disabled set strobe", 64'(unmatched_o), 1);
        rd(grp(5, 1), v); chk("R7 disabled set status", 64'(v), 64'(m_st[5]));
        @(negedge clk);
        chk("R7 strobe one cycle", 64'(unmatched_o), 0);
        inb(set_addr(1), 32'd32);
        chk("R7 bad data strobe", 64'(unmatched_o), 1);
        rd(grp(1, 1), v); chk("R7 bad data status", 64'(v), 64'(m_st[1]));
        inb(set_addr(1) ^ 64'h1_0000_0000, 32'd2);
        chk("R7 addr miss strobe", 64'(unmatched_o), 1);
        rd(grp(1, 1), v); chk("R7 addr miss status", 64'(v), 64'(m_st[1]));

        // R5 capture beats clear on bit 9 of set 1
        @(negedge clk);
        reg_we = 1'b1; reg_addr = grp(1, 1); reg_wdata = 32'h0000_0200;
        iw_valid = 1'b1; iw_addr = set_addr(1); iw_data = 32'd9;
        @(negedge clk);
        reg_we = 1'b0; iw_valid = 1'b0;
        rd(grp(1, 1), v); chk("R5 capture wins", 64'(v), 64'h0000_0200);
        wr(grp(1, 1), 32'h0000_0200);
        rd(grp(1, 1), v); chk("R4 clear alone", 64'(v), 0);

        // R8 two sets share an address
        wr(grp(2, 0), set_addr(6)[31:0]);
        wr(hi_reg(2), set_addr(6)[63:32]);
        inb(set_addr(6), 32'd12);
        rd(grp(2, 1), v); chk("R8 low set takes", 64'(v), 64'h0000_1000);
        rd(grp(6, 1), v); chk("R8 high set skipped", 64'(v), 64'(m_st[6]));
        wr(12'h190, 32'h0000_00DB);
        inb(set_addr(6), 32'd13);
        rd(grp(6, 1), v); chk("R8 falls to next", 64'(v), 64'(m_st[6] | 32'h2000));
        rd(grp(2, 1), v); chk("R8 disabled low set", 64'(v), 64'h0000_1000);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        chk("R1 pending after reset", 64'(set_pending_o), 0);
        rd(grp(6, 1), v); chk("R1 status after reset", 64'(v), 0);
        rd(grp(6, 0), v); chk("R1 lo after reset", 64'(v), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule